// File: doc/BRIEF.md
# Transmit Loopback Word Checker

This block is the on-line self-test for a serial data-bus transmitter. Each message hands its words, one by one, to the transmit encoder; the block keeps a private copy of the final word of the message, whether that word is a command or a data word. When the transmitter starts sending that word, the block opens a response window and expects the same word, with the same sync type, to arrive from the decoder of the receive channel that is currently active. The receive side is wrapped back, so the word is heard as it is sent.

A received word that differs in any of its 16 data bits or its sync type, a word the decoder flags as bad, or no word at all within the window, produces an active-low loop-error pulse of a fixed number of clock cycles (six cycles of a 12 MHz clock is about 0.5 us). Whatever word was heard inside the window is also handed to the DMA writer for one cycle, so the subsystem can store it and compare it against the word it originally loaded (the long-loop check). Encoding, decoding and the DMA engine itself live elsewhere.

Top module: `loopback_checker`

## Requirements
- R1: Out of reset `loop_err_no` is high and `lw_valid_o` is low.
- R2: The reference word and sync type are loaded only when `cap_valid_i` and `cap_last_i` are both high; a capture with `cap_last_i` low leaves the reference unchanged.
- R3: A `tx_go_i` pulse opens the response window only when a reference is held; with no reference held it is ignored and causes neither a pulse nor a forwarded word.
- R4: The first `rx_valid_i` inside the window is compared with the reference on all 16 data bits and on the sync bit (1 = command/status sync, 0 = data sync); equal values with `rx_err_i` low produce no pulse.
- R5: A difference in any single data bit, or in the sync bit, produces a loop-error pulse.
- R6: A looped word with `rx_err_i` high produces a loop-error pulse even when its data and sync match.
- R7: The window covers the WIN_CYC clock edges after the edge that samples `tx_go_i`; a word arriving on the last of them is still compared, and if none arrives by then a loop-error pulse is produced.
- R8: A loop-error pulse holds `loop_err_no` low for exactly PULSE_CYC cycles, starting in the second cycle after the edge that takes the decision.
- R9: The word accepted inside the window is presented on `lw_word_o`/`lw_sync_o` with `lw_valid_o` high for one cycle, in the cycle after it is sampled, whether or not it matched; a word arriving outside the window is neither forwarded nor compared.
- R10: A new error that occurs while `loop_err_no` is low restarts the PULSE_CYC count, so the low level is stretched rather than split.
- R11: Captures while the window is open do not alter the reference, and each decision consumes the reference, so a later `tx_go_i` without a new capture is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock (12 MHz nominal) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cap_valid_i | input | 1 | A word is being handed to the transmitter |
| cap_last_i | input | 1 | The handed word is the final word of its message |
| cap_word_i | input | DATA_W | Data bits of the handed word |
| cap_sync_i | input | 1 | Sync type of the handed word (1 command/status, 0 data) |
| tx_go_i | input | 1 | Transmission of the final word starts; opens the window |
| rx_valid_i | input | 1 | Decoder of the active receive channel has a word |
| rx_word_i | input | DATA_W | Data bits of the received word |
| rx_sync_i | input | 1 | Sync type of the received word |
| rx_err_i | input | 1 | Decoder reports a fault on the received word |
| loop_err_no | output | 1 | Loop-error pulse, active low |
| lw_valid_o | output | 1 | Looped word available for the DMA writer |
| lw_word_o | output | DATA_W | Looped data bits |
| lw_sync_o | output | 1 | Looped sync type |

## Verification
On every cycle the assertions check that the pulse only falls after a trigger and never releases on one, that the window counter stays inside its range, that a forwarded word always follows a receive strobe and never lasts two cycles, and that the reference does not move while the window is open. Whether the comparison actually catches each bit position and the sync type, whether the window edges fall on the right cycle, and whether the pulse has the right width and start only show up in the bench's sweeps, where each message's outcome is predicted from the word pair and the arrival cycle.

// File: rtl/loopchk_pkg.sv
package loopchk_pkg;

    // Phase of the loopback window controller.
    typedef enum logic {
        LW_IDLE = 1'b0,
        LW_WAIT = 1'b1
    } lw_state_e;

endpackage

// File: rtl/loop_ref_latch.sv
module loop_ref_latch #(
    parameter int DATA_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cap_valid_i,
    input  logic              cap_last_i,
    input  logic [DATA_W-1:0] cap_word_i,
    input  logic              cap_sync_i,
    input  logic              hold_i,
    input  logic              clear_i,
    output logic              ref_valid_o,
    output logic [DATA_W-1:0] ref_word_o,
    output logic              ref_sync_o
);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] word;
        logic              sync;
    } ref_t;

    ref_t ref_d, ref_q;

    always_comb begin
        ref_d = ref_q;
        if (clear_i) begin
            ref_d.valid = 1'b0;
        end
        // Only the final word of a message becomes the reference, and the
        // reference is frozen while a window is open.
        if (cap_valid_i && cap_last_i && !hold_i) begin
            ref_d.valid = 1'b1;
            ref_d.word  = cap_word_i;
            ref_d.sync  = cap_sync_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ref_q <= '0;
        end else begin
            ref_q <= ref_d;
        end
    end

    assign ref_valid_o = ref_q.valid;
    assign ref_word_o  = ref_q.word;
    assign ref_sync_o  = ref_q.sync;

    AST_REF_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hold_i |=> ($stable(ref_word_o) && $stable(ref_sync_o))); // R11

endmodule

// File: rtl/loop_window.sv
module loop_window
    import loopchk_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int WIN_CYC = 300
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ref_valid_i,
    input  logic [DATA_W-1:0] ref_word_i,
    input  logic              ref_sync_i,
    input  logic              go_i,
    input  logic              rx_valid_i,
    input  logic [DATA_W-1:0] rx_word_i,
    input  logic              rx_sync_i,
    input  logic              rx_err_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_trig_o,
    output logic              fwd_valid_o,
    output logic [DATA_W-1:0] fwd_word_o,
    output logic              fwd_sync_o
);

    localparam int CNT_W = $clog2(WIN_CYC + 1);
    localparam logic [CNT_W-1:0] WIN_LOAD = CNT_W'(WIN_CYC);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    typedef struct packed {
        lw_state_e         state;
        logic [CNT_W-1:0]  cnt;
        logic              err;
        logic              fwd_v;
        logic [DATA_W-1:0] fwd_w;
        logic              fwd_s;
    } win_t;

    win_t win_d, win_q;
    logic differs;
    logic done;

    // Sync type is part of the compared word.
    assign differs = (rx_word_i != ref_word_i) || (rx_sync_i != ref_sync_i);

    always_comb begin
        win_d       = win_q;
        win_d.err   = 1'b0;
        win_d.fwd_v = 1'b0;
        done        = 1'b0;
        unique case (win_q.state)
            LW_IDLE: begin
                if (go_i && ref_valid_i) begin
                    win_d.state = LW_WAIT;
                    win_d.cnt   = WIN_LOAD;
                end
            end
            LW_WAIT: begin
                if (rx_valid_i) begin
                    win_d.fwd_v = 1'b1;
                    win_d.fwd_w = rx_word_i;
                    win_d.fwd_s = rx_sync_i;
                    win_d.err   = rx_err_i || differs;
                    win_d.state = LW_IDLE;
                    win_d.cnt   = '0;
                    done        = 1'b1;
                end else if (win_q.cnt == CNT_ONE) begin
                    win_d.err   = 1'b1;
                    win_d.state = LW_IDLE;
                    win_d.cnt   = '0;
                    done        = 1'b1;
                end else begin
                    win_d.cnt = win_q.cnt - CNT_ONE;
                end
            end
            default: begin
                win_d.state = LW_IDLE;
                win_d.cnt   = '0;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            win_q <= '{state: LW_IDLE, cnt: '0, err: 1'b0, fwd_v: 1'b0,
                       fwd_w: '0, fwd_s: 1'b0};
        end else begin
            win_q <= win_d;
        end
    end

    assign busy_o      = (win_q.state == LW_WAIT);
    assign done_o      = done;
    assign err_trig_o  = win_q.err;
    assign fwd_valid_o = win_q.fwd_v;
    assign fwd_word_o  = win_q.fwd_w;
    assign fwd_sync_o  = win_q.fwd_s;

    AST_WIN_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (win_q.state == LW_WAIT) |-> (win_q.cnt != '0 && win_q.cnt <= WIN_LOAD)); // R7

    AST_WIN_FWD_CLOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fwd_valid_o |-> (win_q.state == LW_IDLE)); // R9

endmodule

// File: rtl/loop_pulse.sv
module loop_pulse #(
    parameter int PULSE_CYC = 6
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic trig_i,
    output logic err_no
);

    localparam int PC_W = $clog2(PULSE_CYC + 1);
    localparam logic [PC_W-1:0] PULSE_LOAD = PC_W'(PULSE_CYC);

    typedef struct packed {
        logic [PC_W-1:0] cnt;
        logic            low;
    } pulse_t;

    pulse_t pul_d, pul_q;

    always_comb begin
        pul_d = pul_q;
        if (trig_i) begin
            pul_d.cnt = PULSE_LOAD;
        end else if (pul_q.cnt != '0) begin
            pul_d.cnt = pul_q.cnt - PC_W'(1);
        end
        pul_d.low = (pul_d.cnt != '0);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pul_q <= '0;
        end else begin
            pul_q <= pul_d;
        end
    end

    assign err_no = !pul_q.low;

    AST_PULSE_FALL_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(err_no) |-> $past(trig_i)); // R8

    AST_PULSE_NO_RELEASE_ON_TRIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(err_no) |-> !$past(trig_i)); // R10

endmodule

// File: rtl/loopback_checker.sv
module loopback_checker #(
    parameter int DATA_W    = 16,
    parameter int WIN_CYC   = 300,
    parameter int PULSE_CYC = 6
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cap_valid_i,
    input  logic              cap_last_i,
    input  logic [DATA_W-1:0] cap_word_i,
    input  logic              cap_sync_i,
    input  logic              tx_go_i,
    input  logic              rx_valid_i,
    input  logic [DATA_W-1:0] rx_word_i,
    input  logic              rx_sync_i,
    input  logic              rx_err_i,
    output logic              loop_err_no,
    output logic              lw_valid_o,
    output logic [DATA_W-1:0] lw_word_o,
    output logic              lw_sync_o
);

    logic              ref_valid;
    logic [DATA_W-1:0] ref_word;
    logic              ref_sync;
    logic              win_busy;
    logic              win_done;
    logic              err_trig;

    loop_ref_latch #(
        .DATA_W (DATA_W)
    ) u_ref (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .cap_valid_i (cap_valid_i),
        .cap_last_i  (cap_last_i),
        .cap_word_i  (cap_word_i),
        .cap_sync_i  (cap_sync_i),
        .hold_i      (win_busy),
        .clear_i     (win_done),
        .ref_valid_o (ref_valid),
        .ref_word_o  (ref_word),
        .ref_sync_o  (ref_sync)
    );

    loop_window #(
        .DATA_W  (DATA_W),
        .WIN_CYC (WIN_CYC)
    ) u_win (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .ref_valid_i (ref_valid),
        .ref_word_i  (ref_word),
        .ref_sync_i  (ref_sync),
        .go_i        (tx_go_i),
        .rx_valid_i  (rx_valid_i),
        .rx_word_i   (rx_word_i),
        .rx_sync_i   (rx_sync_i),
        .rx_err_i    (rx_err_i),
        .busy_o      (win_busy),
        .done_o      (win_done),
        .err_trig_o  (err_trig),
        .fwd_valid_o (lw_valid_o),
        .fwd_word_o  (lw_word_o),
        .fwd_sync_o  (lw_sync_o)
    );

    loop_pulse #(
        .PULSE_CYC (PULSE_CYC)
    ) u_pulse (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .trig_i (err_trig),
        .err_no (loop_err_no)
    );

    AST_FWD_HAS_RX: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lw_valid_o |-> $past(rx_valid_i)); // R9

    AST_FWD_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lw_valid_o |=> !lw_valid_o); // R9

endmodule

// File: tb/loopback_checker_test.sv
module loopback_checker_test;

    localparam int DW  = 16;
    localparam int WIN = 8;
    localparam int PUL = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cap_valid = 1'b0, cap_last = 1'b0, cap_sync = 1'b0;
    logic [DW-1:0] cap_word = '0;
    logic          go = 1'b0;
    logic          rx_valid = 1'b0, rx_sync = 1'b0, rx_err = 1'b0;
    logic [DW-1:0] rx_word = '0;
    logic          err_n, lw_valid, lw_sync;
    logic [DW-1:0] lw_word;

    int total = 0;
    int bad   = 0;
    int low_cnt = 0;
    int lw_cnt  = 0;
    logic [DW-1:0] seen_word;
    logic          seen_sync;

    always #4 clk = ~clk;

    loopback_checker #(
        .DATA_W (DW), .WIN_CYC (WIN), .PULSE_CYC (PUL)
    ) uut (
        .clk_i (clk), .rst_ni (rst_n),
        .cap_valid_i (cap_valid), .cap_last_i (cap_last),
        .cap_word_i (cap_word), .cap_sync_i (cap_sync),
        .tx_go_i (go),
        .rx_valid_i (rx_valid), .rx_word_i (rx_word),
        .rx_sync_i (rx_sync), .rx_err_i (rx_err),
        .loop_err_no (err_n), .lw_valid_o (lw_valid),
        .lw_word_o (lw_word), .lw_sync_o (lw_sync)
    );

    // Output monitor, sampling mid-cycle.
    always @(negedge clk) begin
        if (!err_n) low_cnt <= low_cnt + 1;
        if (lw_valid) begin
            lw_cnt    <= lw_cnt + 1;
            seen_word <= lw_word;
            seen_sync <= lw_sync;
        end
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clr_in();
        cap_valid = 1'b0; cap_last = 1'b0; cap_word = '0; cap_sync = 1'b0;
        go = 1'b0; rx_valid = 1'b0; rx_word = '0; rx_sync = 1'b0; rx_err = 1'b0;
    endtask

    task automatic cap(input logic [DW-1:0] w, input logic s, input logic last);
        @(negedge clk); clr_in();
        cap_valid = 1'b1; cap_last = last; cap_word = w; cap_sync = s;
    endtask

    task automatic fire();
        @(negedge clk); clr_in(); go = 1'b1;
    endtask

    task automatic rx(input logic [DW-1:0] w, input logic s, input logic e);
        @(negedge clk); clr_in();
        rx_valid = 1'b1; rx_word = w; rx_sync = s; rx_err = e;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); clr_in();
        end
    endtask

    task automatic begin_msg();
        @(posedge clk); #1;
        low_cnt = 0; lw_cnt = 0;
    endtask

    task automatic settle();
        idle(WIN + PUL + 4);
    endtask

    // One message: capture final word, fire, wait gap cycles, loop back.
    task automatic msg(input logic [DW-1:0] w, input logic s, input int gap,
                       input logic do_rx, input logic [DW-1:0] rw, input logic rs,
                       input logic re, input int exp_low, input string req);
        int exp_lw;
        begin_msg();
        cap(w, s, 1'b1);
        fire();
        idle(gap);
        if (do_rx) rx(rw, rs, re);
        settle();
        exp_lw = (do_rx && gap < WIN) ? 1 : 0;
        chk(low_cnt == exp_low, req, low_cnt, exp_low);
        chk(lw_cnt == exp_lw, "R9 forward count", lw_cnt, exp_lw);
        if (exp_lw == 1)
            chk(seen_word == rw && seen_sync == rs, "R9 forwarded word",
                {15'd0, seen_sync, seen_word}, {15'd0, rs, rw});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [DW-1:0] w;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(err_n == 1'b1, "R1 err_n in reset", err_n, 1);
        chk(lw_valid == 1'b0, "R1 lw_valid in reset", lw_valid, 0);
        rst_n = 1'b1;
        idle(2);
        chk(err_n == 1'b1 && lw_valid == 1'b0, "R1 after reset",
            {err_n, lw_valid}, 2);

        // R4: matching loopbacks, walking patterns, both sync types
        for (int i = 0; i < DW; i++) begin
            for (int s = 0; s < 2; s++) begin
                w = DW'(16'h1 << i) ^ DW'(i * 16'h0f0f);
                msg(w, s[0], i % WIN, 1'b1, w, s[0], 1'b0, 0, "R4 match no pulse");
            end
        end

        // R5: every single-bit data mismatch and the sync mismatch
        for (int i = 0; i < DW; i++) begin
            w = DW'(i * 16'h1357) ^ 16'ha5a5;
            msg(w, i[0], 0, 1'b1, w ^ DW'(16'h1 << i), i[0], 1'b0, PUL, "R5 data bit mismatch");
        end
        msg(16'h3c3c, 1'b1, 2, 1'b1, 16'h3c3c, 1'b0, 1'b0, PUL, "R5 sync mismatch");
        msg(16'h3c3c, 1'b0, 2, 1'b1, 16'h3c3c, 1'b1, 1'b0, PUL, "R5 sync mismatch");

        // R6: decoder fault on an otherwise matching word
        msg(16'h8001, 1'b0, 1, 1'b1, 16'h8001, 1'b0, 1'b1, PUL, "R6 rx error flag");

        // R7: last window edge accepted, one later is a timeout, none at all
        msg(16'h0ff0, 1'b1, WIN - 1, 1'b1, 16'h0ff0, 1'b1, 1'b0, 0, "R7 last window edge");
        msg(16'h0ff0, 1'b1, WIN, 1'b1, 16'h0ff0, 1'b1, 1'b0, PUL, "R7 late word timeout");
        msg(16'h1234, 1'b0, 0, 1'b0, 16'h0, 1'b0, 1'b0, PUL, "R7 no word timeout");

        // R8: pulse start cycle and width
        begin_msg();
        cap(16'h5555, 1'b0, 1'b1);
        fire();
        rx(16'h5554, 1'b0, 1'b0);
        @(negedge clk); clr_in();
        chk(lw_valid == 1'b1 && err_n == 1'b1, "R8 cycle after decision",
            {lw_valid, err_n}, 3);
        @(negedge clk);
        chk(err_n == 1'b0, "R8 low in second cycle", err_n, 0);
        settle();
        chk(low_cnt == PUL, "R8 pulse width", low_cnt, PUL);

        // R3 / R11: fire without a held reference (consumed above)
        begin_msg();
        fire();
        rx(16'hdead, 1'b1, 1'b0);
        settle();
        chk(low_cnt == 0 && lw_cnt == 0, "R3 fire without reference",
            {low_cnt, lw_cnt}, 0);

        // R2: non-final capture does not replace the reference
        begin_msg();
        cap(16'hc001, 1'b1, 1'b1);
        cap(16'h7777, 1'b0, 1'b0);
        fire();
        rx(16'hc001, 1'b1, 1'b0);
        settle();
        chk(low_cnt == 0 && lw_cnt == 1, "R2 non-final capture ignored",
            {low_cnt, lw_cnt}, 1);

        // R11: capture inside the window ignored; reference consumed after
        begin_msg();
        cap(16'h2468, 1'b0, 1'b1);
        fire();
        cap(16'h9999, 1'b1, 1'b1);
        rx(16'h2468, 1'b0, 1'b0);
        idle(2);
        fire();
        rx(16'h9999, 1'b1, 1'b0);
        settle();
        chk(low_cnt == 0, "R11 capture in window ignored", low_cnt, 0);
        chk(lw_cnt == 1, "R11 reference consumed", lw_cnt, 1);

        // R10: second error three cycles after the first stretches the pulse
        begin_msg();
        cap(16'h0001, 1'b0, 1'b1);
        fire();
        rx(16'h0002, 1'b0, 1'b0);
        cap(16'h0003, 1'b0, 1'b1);
        fire();
        rx(16'h0004, 1'b0, 1'b0);
        settle();
        chk(low_cnt == PUL + 3, "R10 retrigger stretch", low_cnt, PUL + 3);
        chk(lw_cnt == 2, "R10 both words forwarded", lw_cnt, 2);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule